// File: doc/BRIEF.md
# SCSI Host Adapter Interrupt and Status Register Block

This block is the byte-wide register front end of a SCSI host adapter. It holds the status register, the interrupt-cause register and the sequence-step register, and it drives a single level-sensitive interrupt line toward the host. Engines elsewhere in the adapter post what has happened through strobe inputs. Those strobes OR bits into the cause and status registers, load the step and FIFO-flags registers, and request the interrupt. The host takes the interrupt by reading the cause register, and that read acknowledges it.

The block also decodes a small set of host commands: flush, chip reset, bus reset, message accept, and enable or disable selection. It holds the three transfer-count byte registers and configuration register 1. The upper count register returns a fixed identification byte until software first writes it, so a driver can identify the part. SCSI phase handling, device models and data movement are handled outside this block.

Register addresses (4 bits): 0 count low, 1 count mid, 2 count high, 3 command, 4 status (read-only), 5 cause (read-only, destructive), 6 step (read-only), 7 FIFO flags (read-only), 8 configuration 1. Any other address reads 0 and ignores writes. Reads and writes are single-cycle strobes. Read data is registered and is valid in the cycle after `rd_en`.

Top module: `scsi_irqstat_top`

## Requirements
- R1: The interrupt bit (status bit 7) and `irq` become 1 only in the cycle after a raise request (`ev_raise`, bus reset, message accept or disable selection). Once set, they stay 1 until a cause read or a reset. Another raise while they are set changes nothing.
- R2: A read at address 5 returns the cause value present before the read, and the cause register is 0 afterwards.
- R3: The same read clears status bit 4 (terminal count) and status bit 7, sets the step register to 0, and drops `irq` one cycle later.
- R4: A read at address 2 returns the `CHIP_ID` parameter until address 2 has been written after a reset. After that write, the read returns the stored byte.
- R5: A write to address 0, 1 or 2 clears status bit 4.
- R6: Command code 0x03 (bus reset) sets cause bit 7 and raises the interrupt, unless configuration 1 bit 6 is set. In that case it does nothing.
- R7: Command code 0x12 (message accept) sets cause bit 5, clears the step and flags registers, and raises the interrupt.
- R8: Reset, whether `rst_n` low or command code 0x02, clears every register, loads configuration 1 with 7, forgets the upper-count write, and drops `irq`.
- R9: Command code 0x44 (enable selection) clears the cause register without raising the interrupt. Command code 0x45 (disable selection) clears it and raises the interrupt.
- R10: Event bits posted in the same cycle as a cause read survive that read, and a raise request in that cycle keeps `irq` at 1.
- R11: Command code 0x01 (flush) clears the flags register.
- R12: `ev_cause` ORs into the cause register and `ev_stat` bits 6..0 OR into the status register. `ev_step_we` loads the step register from `ev_val`[2:0], and `ev_flags_we` loads the flags register from `ev_val`. Command bit 7 is ignored in decoding, and the command register reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| ev_cause | input | 8 | Cause bits to set |
| ev_stat | input | 8 | Status bits to set (bit 7 ignored) |
| ev_step_we | input | 1 | Load step register |
| ev_flags_we | input | 1 | Load flags register |
| ev_val | input | 8 | Value for step or flags load |
| ev_raise | input | 1 | Request interrupt |
| irq | output | 1 | Level interrupt to host |

## Verification
The bench uses the default parameters, with `CHIP_ID` set to 0xA5. That value is distinct from both 0 and the byte the bench writes, so the switch from identification byte to stored byte is visible in readback. The default configuration reset value of 7 leaves the bus-reset report enabled. This lets the bench run the reported and suppressed bus-reset cases back to back with only one configuration write. With 8-bit data, every cause and status bit the requirements name can be posted and read through the ports.

// File: rtl/scsi_irqstat_pkg.sv
// Package: shared widths, register addresses, bit positions and command codes
// for the SCSI interrupt/status register block.
package scsi_irqstat_pkg;
    parameter int ADDR_W = 4;
    parameter int DATA_W = 8;
    parameter int STEP_W = 3;
    parameter int CODE_W = 7;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_MD = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMD    = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 4'd5;
    localparam logic [ADDR_W-1:0] A_STEP   = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CFG1   = 4'd8;

    localparam int ST_INT    = 7;
    localparam int ST_TC     = 4;
    localparam int CA_BUSRST = 7;
    localparam int CA_DISC   = 5;
    localparam int CFG_NOREP = 6;

    localparam logic [CODE_W-1:0] C_FLUSH  = 7'h01;
    localparam logic [CODE_W-1:0] C_RESET  = 7'h02;
    localparam logic [CODE_W-1:0] C_BUSRST = 7'h03;
    localparam logic [CODE_W-1:0] C_MSGACC = 7'h12;
    localparam logic [CODE_W-1:0] C_ENSEL  = 7'h44;
    localparam logic [CODE_W-1:0] C_DISSEL = 7'h45;

    typedef struct packed {
        logic flush;
        logic reset;
        logic busrst;
        logic msgacc;
        logic ensel;
        logic dissel;
    } cmd_act_t;
endpackage

// File: rtl/scsi_cmd_decode.sv
// Command decoder: turns a host write to the command register into
// one-cycle action strobes. Assumes bit 7 of the command is a transfer
// mode flag that does not change the action.
module scsi_cmd_decode
    import scsi_irqstat_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_byte,
    output cmd_act_t          act
);
    logic [CODE_W-1:0] code;
    assign code = cmd_byte[CODE_W-1:0];

    // Match the code against the supported commands.
    always_comb begin
        act        = '0;
        act.flush  = cmd_wr && (code == C_FLUSH);
        act.reset  = cmd_wr && (code == C_RESET);
        act.busrst = cmd_wr && (code == C_BUSRST);
        act.msgacc = cmd_wr && (code == C_MSGACC);
        act.ensel  = cmd_wr && (code == C_ENSEL);
        act.dissel = cmd_wr && (code == C_DISSEL);
    end
endmodule

// File: rtl/scsi_cfg_regs.sv
// Host-written registers: the three transfer-count bytes, the command byte,
// configuration 1, and the flag recording that the upper count byte has
// been written since reset. Assumes soft_rst is one cycle wide.
module scsi_cfg_regs
    import scsi_irqstat_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG1_INIT = 8'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] cnt_md,
    output logic [DATA_W-1:0] cnt_hi,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] cfg1,
    output logic              hi_written
);
    // Store host writes; reset loads the configuration default.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt_lo     <= '0;
            cnt_md     <= '0;
            cnt_hi     <= '0;
            cmd_q      <= '0;
            cfg1       <= CFG1_INIT;
            hi_written <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_CNT_LO: cnt_lo <= wdata;
                A_CNT_MD: cnt_md <= wdata;
                A_CNT_HI: begin
                    cnt_hi     <= wdata;
                    hi_written <= 1'b1;
                end
                A_CMD:  cmd_q <= wdata;
                A_CFG1: cfg1  <= wdata;
                default: ;
            endcase
        end
    end

    // R8: reset reloads configuration 1 and forgets the upper-count write.
    a_r8_soft_reset_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg1 == CFG1_INIT) && !hi_written);
    // R4: after an upper-count write, the written flag is set.
    a_r4_hi_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CNT_HI && !soft_rst) |=> hi_written && cnt_hi == $past(wdata));
endmodule

// File: rtl/scsi_irq_core.sv
// Interrupt/status core: status, cause, step and flags registers plus the
// registered interrupt line. Clears from a cause read or a command are
// applied first, then event strobes and command-set bits are merged, so
// events posted in the same cycle are never lost.
module scsi_irq_core
    import scsi_irqstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_act_t          act,
    input  logic              rep_dis,
    input  logic              cause_rd,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] ev_cause,
    input  logic [DATA_W-1:0] ev_stat,
    input  logic              ev_step_we,
    input  logic              ev_flags_we,
    input  logic [DATA_W-1:0] ev_val,
    input  logic              ev_raise,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] cause,
    output logic [STEP_W-1:0] step,
    output logic [DATA_W-1:0] flags,
    output logic              irq_q
);
    logic [DATA_W-1:0] st_n, ca_n, fl_n;
    logic [STEP_W-1:0] sp_n;
    logic              raise;
    logic              busrst_ok;

    assign busrst_ok = act.busrst && !rep_dis;
    assign raise     = ev_raise || busrst_ok || act.msgacc || act.dissel;

    // Compute the next register state: clears first, then sets.
    always_comb begin
        st_n = status;
        ca_n = cause;
        sp_n = step;
        fl_n = flags;
        if (cause_rd) begin
            ca_n         = '0;
            sp_n         = '0;
            st_n[ST_TC]  = 1'b0;
            st_n[ST_INT] = 1'b0;
        end
        if (cnt_wr)                  st_n[ST_TC] = 1'b0;
        if (act.ensel || act.dissel) ca_n = '0;
        if (act.flush)               fl_n = '0;
        if (act.msgacc) begin
            ca_n[CA_DISC] = 1'b1;
            sp_n          = '0;
            fl_n          = '0;
        end
        if (busrst_ok) ca_n[CA_BUSRST] = 1'b1;
        ca_n = ca_n | ev_cause;
        st_n[DATA_W-2:0] = st_n[DATA_W-2:0] | ev_stat[DATA_W-2:0];
        if (ev_step_we)  sp_n = ev_val[STEP_W-1:0];
        if (ev_flags_we) fl_n = ev_val;
        if (raise)       st_n[ST_INT] = 1'b1;
    end

    // Register state and the interrupt line; both resets clear everything.
    always_ff @(posedge clk) begin
        if (!rst_n || act.reset) begin
            status <= '0;
            cause  <= '0;
            step   <= '0;
            flags  <= '0;
            irq_q  <= 1'b0;
        end else begin
            status <= st_n;
            cause  <= ca_n;
            step   <= sp_n;
            flags  <= fl_n;
            irq_q  <= st_n[ST_INT];
        end
    end

    // R1: the line rises only after a raise request.
    a_r1_rise_needs_raise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(raise));
    // R1: the line tracks the status interrupt bit.
    a_r1_line_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == status[ST_INT]);
    // R3: a cause read with no raise drops the line.
    a_r3_read_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !raise) |=> !irq_q && step == '0);
    // R2: a cause read with nothing new posted leaves the cause at zero.
    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && ev_cause == '0 && !busrst_ok && !act.msgacc) |=> cause == '0);
    // R5: a count write with no terminal-count event clears that bit.
    a_r5_cnt_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ev_stat[ST_TC]) |=> !status[ST_TC]);
    // R9: enable selection with no event leaves the cause clear.
    a_r9_ensel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (act.ensel && ev_cause == '0 && !act.reset) |=> cause == '0);
endmodule

// File: rtl/scsi_irqstat_top.sv
// Top of the SCSI interrupt/status register block: command decode,
// host-written registers, interrupt core and the registered read mux.
// Assumes the host never issues rd_en and wr_en in the same cycle.
module scsi_irqstat_top
    import scsi_irqstat_pkg::*;
#(
    parameter logic [DATA_W-1:0] CHIP_ID   = 8'hA5,
    parameter logic [DATA_W-1:0] CFG1_INIT = 8'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] ev_cause,
    input  logic [DATA_W-1:0] ev_stat,
    input  logic              ev_step_we,
    input  logic              ev_flags_we,
    input  logic [DATA_W-1:0] ev_val,
    input  logic              ev_raise,
    output logic              irq
);
    cmd_act_t          act;
    logic [DATA_W-1:0] cnt_lo, cnt_md, cnt_hi, cmd_q, cfg1;
    logic              hi_written;
    logic [DATA_W-1:0] status, cause, flags;
    logic [STEP_W-1:0] step;
    logic [DATA_W-1:0] rd_mux;
    logic              cause_rd, cnt_wr;

    assign cause_rd = rd_en && (addr == A_CAUSE);
    assign cnt_wr   = wr_en && (addr == A_CNT_LO || addr == A_CNT_MD || addr == A_CNT_HI);

    scsi_cmd_decode u_dec (
        .cmd_wr   (wr_en && addr == A_CMD),
        .cmd_byte (wdata),
        .act      (act)
    );

    scsi_cfg_regs #(.CFG1_INIT(CFG1_INIT)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (act.reset),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cnt_lo     (cnt_lo),
        .cnt_md     (cnt_md),
        .cnt_hi     (cnt_hi),
        .cmd_q      (cmd_q),
        .cfg1       (cfg1),
        .hi_written (hi_written)
    );

    scsi_irq_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .rep_dis     (cfg1[CFG_NOREP]),
        .cause_rd    (cause_rd),
        .cnt_wr      (cnt_wr),
        .ev_cause    (ev_cause),
        .ev_stat     (ev_stat),
        .ev_step_we  (ev_step_we),
        .ev_flags_we (ev_flags_we),
        .ev_val      (ev_val),
        .ev_raise    (ev_raise),
        .status      (status),
        .cause       (cause),
        .step        (step),
        .flags       (flags),
        .irq_q       (irq)
    );

    // Select the addressed register for readback.
    always_comb begin
        case (addr)
            A_CNT_LO: rd_mux = cnt_lo;
            A_CNT_MD: rd_mux = cnt_md;
            A_CNT_HI: rd_mux = hi_written ? cnt_hi : CHIP_ID;
            A_CMD:    rd_mux = cmd_q;
            A_STAT:   rd_mux = status;
            A_CAUSE:  rd_mux = cause;
            A_STEP:   rd_mux = {{(DATA_W-STEP_W){1'b0}}, step};
            A_FLAGS:  rd_mux = flags;
            A_CFG1:   rd_mux = cfg1;
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R2: a cause read returns the value held before the read.
    a_r2_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd |=> rdata == $past(cause));
endmodule

// File: tb/tb_scsi_irqstat_top.sv
// Scoreboard bench: read tasks push expected bytes into a queue and a monitor
// pops and compares each one when the registered read data is valid.
module tb_scsi_irqstat_top;
    import scsi_irqstat_pkg::*;

    localparam logic [7:0] ID = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] ev_cause = '0, ev_stat = '0, ev_val = '0;
    logic       ev_step_we = 1'b0, ev_flags_we = 1'b0, ev_raise = 1'b0;
    logic       irq;

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    scsi_irqstat_top #(.CHIP_ID(ID)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_cause(ev_cause), .ev_stat(ev_stat),
        .ev_step_we(ev_step_we), .ev_flags_we(ev_flags_we), .ev_val(ev_val),
        .ev_raise(ev_raise), .irq(irq)
    );

    // Monitor: compare registered read data against the scoreboard.
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ev(input logic [7:0] c, input logic [7:0] s, input logic r);
        ev_cause = c; ev_stat = s; ev_raise = r;
        @(negedge clk);
        ev_cause = '0; ev_stat = '0; ev_raise = 1'b0;
    endtask

    task automatic ld(input logic step_we, input logic flags_we, input logic [7:0] v);
        ev_step_we = step_we; ev_flags_we = flags_we; ev_val = v;
        @(negedge clk);
        ev_step_we = 1'b0; ev_flags_we = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk_irq(1'b0, "R8 irq after reset");
        rd(A_STAT,   8'h00, "R8 status reset");
        rd(A_CAUSE,  8'h00, "R8 cause reset");
        rd(A_CFG1,   8'h07, "R8 cfg1 reset");
        rd(A_CNT_HI, ID,    "R4 chip id before write");
        rd(4'hF,     8'h00, "R12 unmapped reads zero");
        // R1 / R12: post cause, terminal count, step, then raise
        ld(1'b1, 1'b0, 8'h03);
        ev(8'h18, 8'h13, 1'b1);
        chk_irq(1'b1, "R1 irq after raise");
        rd(A_STAT, 8'h93, "R12 status set bits");
        ev(8'h00, 8'h00, 1'b1);
        chk_irq(1'b1, "R1 second raise holds");
        rd(A_STEP, 8'h03, "R12 step load");
        // R2 / R3 destructive read
        rd(A_CAUSE, 8'h18, "R2 cause returned");
        chk_irq(1'b0, "R3 irq dropped by read");
        rd(A_CAUSE, 8'h00, "R2 cause cleared");
        rd(A_STAT,  8'h03, "R3 tc and int cleared");
        rd(A_STEP,  8'h00, "R3 step cleared");
        // R4 upper count write
        wr(A_CNT_HI, 8'h5A);
        rd(A_CNT_HI, 8'h5A, "R4 stored after write");
        // R5 count writes clear terminal count
        ev(8'h00, 8'h10, 1'b0);
        wr(A_CNT_LO, 8'h11);
        rd(A_STAT, 8'h03, "R5 lo write clears tc");
        ev(8'h00, 8'h10, 1'b0);
        wr(A_CNT_MD, 8'h22);
        rd(A_STAT, 8'h03, "R5 mid write clears tc");
        rd(A_CNT_MD, 8'h22, "R5 mid stored");
        // R6 bus reset reported
        wr(A_CMD, 8'h03);
        chk_irq(1'b1, "R6 bus reset raises");
        rd(A_CMD, 8'h03, "R12 command readback");
        rd(A_CAUSE, 8'h80, "R6 bus reset cause");
        // R6 suppressed
        wr(A_CFG1, 8'h47);
        wr(A_CMD, 8'h03);
        chk_irq(1'b0, "R6 suppressed no irq");
        rd(A_CAUSE, 8'h00, "R6 suppressed no cause");
        // R7 message accept (bit 7 set in command is ignored)
        ld(1'b1, 1'b1, 8'h05);
        wr(A_CMD, 8'h92);
        chk_irq(1'b1, "R7 msg accept raises");
        rd(A_STEP,  8'h00, "R7 step cleared");
        rd(A_FLAGS, 8'h00, "R7 flags cleared");
        rd(A_CAUSE, 8'h20, "R7 disconnect cause");
        // R11 flush
        ld(1'b0, 1'b1, 8'h09);
        rd(A_FLAGS, 8'h09, "R12 flags load");
        wr(A_CMD, 8'h01);
        rd(A_FLAGS, 8'h00, "R11 flush clears flags");
        // R9 selection enable / disable
        ev(8'h08, 8'h00, 1'b0);
        wr(A_CMD, 8'h44);
        chk_irq(1'b0, "R9 enable no irq");
        rd(A_CAUSE, 8'h00, "R9 enable clears cause");
        ev(8'h08, 8'h00, 1'b0);
        wr(A_CMD, 8'h45);
        chk_irq(1'b1, "R9 disable raises");
        rd(A_CAUSE, 8'h00, "R9 disable clears cause");
        // R10 event in the same cycle as a cause read
        ev_cause = 8'h04; ev_raise = 1'b1;
        rd(A_CAUSE, 8'h00, "R10 read returns old cause");
        ev_cause = '0; ev_raise = 1'b0;
        chk_irq(1'b1, "R10 irq kept by raise");
        rd(A_CAUSE, 8'h04, "R10 event survives read");
        // R8 reset command
        ev(8'h02, 8'h05, 1'b1);
        wr(A_CMD, 8'h02);
        chk_irq(1'b0, "R8 reset cmd drops irq");
        rd(A_CFG1,   8'h07, "R8 cfg1 reloaded");
        rd(A_CNT_HI, ID,    "R4 chip id after reset");
        rd(A_STAT,   8'h00, "R8 status cleared");
        rd(A_CNT_LO, 8'h00, "R8 count cleared");
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule